// File: doc/BRIEF.md
# Processor Input Pin Conditioner

This block sits between the raw control pins of a processor core and the core itself. Seven pins come in without any timing relation to the core clock: a time-base run enable, an external interrupt, a system-management interrupt, a machine-check request, a checkstop, a hard reset and a soft reset. Each pin first passes through a chain of synchronizer flops. The block then compares the synchronized level with a stored copy of the level it last acted on, so it reacts only to real changes and never to a repeated level.

Each pin has its own sensitivity. The two interrupt pins and the soft reset are active-high levels, and each one mirrors its level into its own bit of a pending word. The machine-check pin reacts only to a falling edge, which sets a sticky pending bit that the core clears with an acknowledge. The checkstop pin is active low and halts the core until the next reset. The hard reset pin is active low and sends a single reset pulse to the core. The time-base enable is an active-high level that lets the time base run or freezes it. A single interrupt request is the OR of the whole pending word.

Top module: `pinCond`

## Requirements
- R1: While `rstN` is low and just after its release, `pendingOut` is 0 and `irqReq`, `coreHalt`, `coreRst` and `tbRun` are 0. The stored pin levels reset to each pin's inactive level: low for `tbEnIn`, `extIrqIn`, `smiIn` and `softRstIn`, high for `mchkNIn`, `ckstopNIn` and `hresetNIn`.
- R2: A pin change driven before clock edge k first shows at the outputs after edge k+2 (two synchronizer flops and one output register), and not after edge k+1.
- R3: `pendingOut[0]` follows the level of `extIrqIn` (active high).
- R4: `pendingOut[1]` follows the level of `smiIn` (active high).
- R5: A 1-to-0 transition of `mchkNIn` sets `pendingOut[2]`. A 0-to-1 transition changes nothing.
- R6: `pendingOut[2]` stays set until a cycle with `ackIn[2]` high clears it. If a new falling edge arrives in the same cycle, the set wins. `ackIn[0]`, `ackIn[1]` and `ackIn[3]` have no effect on the pending word.
- R7: `pendingOut[3]` follows the level of `softRstIn` (active high).
- R8: `irqReq` is high exactly when `pendingOut` is nonzero.
- R9: A low level on `ckstopNIn` sets `coreHalt`. A later return high does not clear it. Only `rstN` clears it.
- R10: A 1-to-0 transition of `hresetNIn` gives `coreRst` high for exactly one cycle. Holding the pin low or releasing it gives no further pulse.
- R11: `tbRun` follows the level of `tbEnIn` (high runs, low freezes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low reset |
| tbEnIn | input | 1 | Time-base run enable pin, active high |
| extIrqIn | input | 1 | External interrupt pin, active high |
| smiIn | input | 1 | System-management interrupt pin, active high |
| mchkNIn | input | 1 | Machine-check pin, falling-edge sensitive |
| ckstopNIn | input | 1 | Checkstop pin, active low |
| hresetNIn | input | 1 | Hard reset pin, active low |
| softRstIn | input | 1 | Soft reset pin, active high |
| ackIn | input | PEND_W | Per-bit pending acknowledge from the core (only bit 2 acts) |
| pendingOut | output | PEND_W | Pending word: bit 0 external, 1 system-management, 2 machine check, 3 soft reset |
| irqReq | output | 1 | OR of the pending word |
| coreHalt | output | 1 | Sticky core halt from checkstop |
| coreRst | output | 1 | One-cycle core reset request |
| tbRun | output | 1 | Time base runs when high |

## Verification
Every pin-driven result is due after the third rising edge that follows the drive: two edges go to the synchronizer and one to the output register. The bench drives on falling edges and samples on the falling edge after those three rising edges. For the hard-reset pulse it also samples one cycle early and one cycle late, to show that the pulse lasts a single cycle. An acknowledge acts on the very next rising edge because it does not pass through the synchronizer, so its effect is sampled one falling edge after the drive.

// File: rtl/pinCondPkg.sv
package pinCondPkg;
  localparam int PIN_W   = 7;
  localparam int PIN_TB  = 0;
  localparam int PIN_EXT = 1;
  localparam int PIN_SMI = 2;
  localparam int PIN_MCK = 3;
  localparam int PIN_CKS = 4;
  localparam int PIN_HRS = 5;
  localparam int PIN_SRS = 6;
  // inactive level of every pin, used as reset value of all stored levels
  localparam logic [PIN_W-1:0] PIN_IDLE = 7'b0111000;

  localparam int PEND_W  = 4;
  localparam int PB_EXT  = 0;
  localparam int PB_SMI  = 1;
  localparam int PB_MCK  = 2;
  localparam int PB_SRS  = 3;

  typedef struct packed {
    logic [PEND_W-1:0] lvlSet;
    logic [PEND_W-1:0] lvlClr;
    logic              mckSet;
    logic              haltSet;
    logic              rstFire;
    logic              tbStart;
    logic              tbStop;
  } strobeT;
endpackage

// File: rtl/pinSync.sv
module pinSync #(
  parameter int STAGES = 2,
  parameter int W = 7,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinsRaw,
  output logic [W-1:0] pinsSync
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= IDLE;
    else       chain[0] <= pinsRaw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= IDLE;
      else       chain[s] <= chain[s-1];
    end
  end

  assign pinsSync = chain[STAGES-1];
endmodule

// File: rtl/pinCondCtrl.sv
module pinCondCtrl
  import pinCondPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIN_W-1:0] pinsSync,
  output strobeT           strobes
);
  logic [PIN_W-1:0] lastLvl;
  logic [PIN_W-1:0] changed;
  logic [PIN_W-1:0] wentHigh;
  logic [PIN_W-1:0] wentLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastLvl <= PIN_IDLE;
    else       lastLvl <= pinsSync;
  end

  assign changed  = pinsSync ^ lastLvl;
  assign wentHigh = changed & pinsSync;
  assign wentLow  = changed & ~pinsSync;

  always_comb begin
    strobes = '0;
    strobes.lvlSet[PB_EXT] = wentHigh[PIN_EXT];
    strobes.lvlClr[PB_EXT] = wentLow[PIN_EXT];
    strobes.lvlSet[PB_SMI] = wentHigh[PIN_SMI];
    strobes.lvlClr[PB_SMI] = wentLow[PIN_SMI];
    strobes.lvlSet[PB_SRS] = wentHigh[PIN_SRS];
    strobes.lvlClr[PB_SRS] = wentLow[PIN_SRS];
    strobes.mckSet  = wentLow[PIN_MCK];
    strobes.haltSet = wentLow[PIN_CKS];
    strobes.rstFire = wentLow[PIN_HRS];
    strobes.tbStart = wentHigh[PIN_TB];
    strobes.tbStop  = wentLow[PIN_TB];
  end
endmodule

// File: rtl/pinCondData.sv
module pinCondData
  import pinCondPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [PEND_W-1:0] ackIn,
  output logic [PEND_W-1:0] pendingOut,
  output logic              irqReq,
  output logic              coreHalt,
  output logic              coreRst,
  output logic              tbRun
);
  logic [PEND_W-1:0] pendNext;

  always_comb begin
    pendNext = (pendingOut | strobes.lvlSet) & ~strobes.lvlClr;
    if (strobes.mckSet)     pendNext[PB_MCK] = 1'b1;
    else if (ackIn[PB_MCK]) pendNext[PB_MCK] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingOut <= '0;
      irqReq     <= 1'b0;
      coreHalt   <= 1'b0;
      coreRst    <= 1'b0;
      tbRun      <= 1'b0;
    end else begin
      pendingOut <= pendNext;
      irqReq     <= |pendNext;
      coreHalt   <= coreHalt | strobes.haltSet;
      coreRst    <= strobes.rstFire;
      if (strobes.tbStart)     tbRun <= 1'b1;
      else if (strobes.tbStop) tbRun <= 1'b0;
    end
  end
endmodule

// File: rtl/pinCond.sv
module pinCond
  import pinCondPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tbEnIn,
  input  logic              extIrqIn,
  input  logic              smiIn,
  input  logic              mchkNIn,
  input  logic              ckstopNIn,
  input  logic              hresetNIn,
  input  logic              softRstIn,
  input  logic [PEND_W-1:0] ackIn,
  output logic [PEND_W-1:0] pendingOut,
  output logic              irqReq,
  output logic              coreHalt,
  output logic              coreRst,
  output logic              tbRun
);
  logic [PIN_W-1:0] pinsRaw;
  logic [PIN_W-1:0] pinsSync;
  strobeT           strobes;

  always_comb begin
    pinsRaw          = '0;
    pinsRaw[PIN_TB]  = tbEnIn;
    pinsRaw[PIN_EXT] = extIrqIn;
    pinsRaw[PIN_SMI] = smiIn;
    pinsRaw[PIN_MCK] = mchkNIn;
    pinsRaw[PIN_CKS] = ckstopNIn;
    pinsRaw[PIN_HRS] = hresetNIn;
    pinsRaw[PIN_SRS] = softRstIn;
  end

  pinSync #(.STAGES(SYNC_STAGES), .W(PIN_W), .IDLE(PIN_IDLE)) u_sync (
    .clk(clk), .rstN(rstN), .pinsRaw(pinsRaw), .pinsSync(pinsSync)
  );

  pinCondCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .pinsSync(pinsSync), .strobes(strobes)
  );

  pinCondData u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ackIn(ackIn),
    .pendingOut(pendingOut), .irqReq(irqReq), .coreHalt(coreHalt),
    .coreRst(coreRst), .tbRun(tbRun)
  );
endmodule

// File: rtl/pinCondChk.sv
module pinCondChk
  import pinCondPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [PEND_W-1:0] ackIn,
  input logic [PEND_W-1:0] pendingOut,
  input logic              irqReq,
  input logic              coreHalt,
  input logic              coreRst
);
  p_irq_any_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (pendingOut != '0));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    coreHalt |=> coreHalt);

  p_rst_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    coreRst |=> !coreRst);

  p_mck_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pendingOut[PB_MCK] && !ackIn[PB_MCK]) |=> pendingOut[PB_MCK]);
endmodule

bind pinCond pinCondChk u_chk (
  .clk(clk), .rstN(rstN), .ackIn(ackIn), .pendingOut(pendingOut),
  .irqReq(irqReq), .coreHalt(coreHalt), .coreRst(coreRst)
);

// File: tb/test_pinCond.sv
module test_pinCond;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tbEnIn = 1'b0, extIrqIn = 1'b0, smiIn = 1'b0, softRstIn = 1'b0;
  logic mchkNIn = 1'b1, ckstopNIn = 1'b1, hresetNIn = 1'b1;
  logic [3:0] ackIn = 4'b0;
  logic [3:0] pendingOut;
  logic irqReq, coreHalt, coreRst, tbRun;

  int nChecks = 0;
  int nFails = 0;
  logic mckExp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinCond i_pinCond (
    .clk(clk), .rstN(rstN), .tbEnIn(tbEnIn), .extIrqIn(extIrqIn),
    .smiIn(smiIn), .mchkNIn(mchkNIn), .ckstopNIn(ckstopNIn),
    .hresetNIn(hresetNIn), .softRstIn(softRstIn), .ackIn(ackIn),
    .pendingOut(pendingOut), .irqReq(irqReq), .coreHalt(coreHalt),
    .coreRst(coreRst), .tbRun(tbRun)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ackPulse(input logic [3:0] a);
    ackIn = a;
    @(posedge clk);
    @(negedge clk);
    ackIn = 4'b0;
  endtask

  function automatic logic [3:0] expPend();
    return {softRstIn, mckExp, smiIn, extIrqIn};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pending", pendingOut, 4'h0);
    chk("R1 irq", {3'b0, irqReq}, 4'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 halt", {3'b0, coreHalt}, 4'h0);
    chk("R1 corerst", {3'b0, coreRst}, 4'h0);
    chk("R1 tbrun", {3'b0, tbRun}, 4'h0);

    // R2 latency: old value after two edges, new after three
    extIrqIn = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 not yet", pendingOut, 4'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 due", pendingOut, 4'h1);
    extIrqIn = 1'b0;
    settle();

    // R3 R4 R7 R8 sweep of level pins, binary then gray order
    for (int pass = 0; pass < 2; pass++) begin
      for (int v = 0; v < 8; v++) begin
        int g;
        g = (pass == 0) ? v : (v ^ (v >> 1));
        extIrqIn  = g[0];
        smiIn     = g[1];
        softRstIn = g[2];
        settle();
        chk("R3 R4 R7 pending", pendingOut, expPend());
        chk("R8 irq", {3'b0, irqReq}, {3'b0, |expPend()});
      end
    end
    extIrqIn = 1'b0; smiIn = 1'b0; softRstIn = 1'b0;
    settle();
    chk("R8 irq idle", {3'b0, irqReq}, 4'h0);

    // R5 falling edge sets machine check
    mchkNIn = 1'b0; mckExp = 1'b1;
    settle();
    chk("R5 mck set", pendingOut, expPend());
    chk("R8 irq mck only", {3'b0, irqReq}, 4'h1);
    // R6 other ack bits have no effect
    extIrqIn = 1'b1;
    settle();
    ackPulse(4'b1011);
    chk("R6 other acks ignored", pendingOut, expPend());
    // R5 rising edge has no effect
    mchkNIn = 1'b1;
    settle();
    chk("R5 rising no effect", pendingOut, expPend());
    // R6 ack clears
    ackPulse(4'b0100); mckExp = 1'b0;
    chk("R6 ack clears", pendingOut, expPend());
    settle();
    chk("R6 stays clear", pendingOut, expPend());
    // R6 set wins over ack in the same cycle
    mchkNIn = 1'b0;
    ackIn = 4'b0100;
    settle();
    ackIn = 4'b0; mckExp = 1'b1;
    chk("R6 set beats ack", pendingOut, expPend());
    ackPulse(4'b0100); mckExp = 1'b0;
    chk("R6 ack clears again", pendingOut, expPend());
    mchkNIn = 1'b1; extIrqIn = 1'b0;
    settle();
    chk("R3 ext low", pendingOut, 4'h0);

    // R11 time base
    tbEnIn = 1'b1;
    settle();
    chk("R11 run", {3'b0, tbRun}, 4'h1);
    tbEnIn = 1'b0;
    settle();
    chk("R11 freeze", {3'b0, tbRun}, 4'h0);

    // R10 hard reset pulse
    hresetNIn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 early", {3'b0, coreRst}, 4'h0);
    @(posedge clk); @(negedge clk);
    chk("R10 pulse", {3'b0, coreRst}, 4'h1);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R10 held low", {3'b0, coreRst}, 4'h0);
    end
    hresetNIn = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R10 release", {3'b0, coreRst}, 4'h0);
    end

    // R9 checkstop
    ckstopNIn = 1'b0;
    settle();
    chk("R9 halt", {3'b0, coreHalt}, 4'h1);
    ckstopNIn = 1'b1;
    settle();
    chk("R9 sticky", {3'b0, coreHalt}, 4'h1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset clears", {3'b0, coreHalt}, 4'h0);
    chk("R1 pending after reset", pendingOut, 4'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule